// File: doc/BRIEF.md
# Zero-Cross Gain Update Controller

This block sits in front of a programmable-gain stage and decides the moment a newly requested gain value becomes the active gain. A host writes a target gain, and the block holds it as pending. The block applies it only when the audio sample stream passes through zero, so that the gain step lands where the signal carries no energy. This avoids audible clicks and zipper noise.

Some signals sit on one side of zero for a long time. To keep a change from waiting forever on such a signal, a fallback timer runs in frame-sync ticks, one tick per audio frame. When the programmed number of ticks has passed, the pending gain is applied anyway. A 14-bit terminal count sets the timer length. A value of zero turns the fallback off. Small non-zero values are reserved and are raised to a floor.

The multiplier that uses the gain, the host command decoding and the analog path all lie outside this block.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset, `gain_active` is 0, `change_pending` is 0, and the terminal count is 0x1FFF, so the first timed change takes 8192 ticks.
- R2: A gain write whose value differs from `gain_active` sets `change_pending` at the next clock edge. It leaves `gain_active` unchanged until a crossing or a timeout occurs.
- R3: A crossing is a sample accepted with `smp_valid`=1 that either equals exactly zero, or has a sign bit (the MSB, two's complement) different from the sign bit of the previous accepted sample. Samples presented with `smp_valid`=0 are ignored, both for detection and for sign tracking.
- R4: While a change is pending, a crossing loads the pending gain into `gain_active` at the same clock edge that accepts the crossing sample. `change_pending` clears at that same edge.
- R5: For an effective terminal count N of 0x0400 or more, the pending gain is applied at the edge that accepts the (N+1)-th `fsync_tick` after the write, and not before. `change_pending` clears at that same edge.
- R6: A terminal count of 0x0000 disables the fallback. The change then waits for a crossing without limit.
- R7: Terminal counts from 0x0001 to 0x03FF behave exactly like 0x0400.
- R8: A gain write while a change is pending replaces the pending value and restarts the tick count from zero.
- R9: A gain write equal to `gain_active` leaves `change_pending` at 0, and cancels any change that was pending.
- R10: A terminal-count write while a change is pending does not alter that change's timeout. It applies from the next gain write onward.
- R11: When a differing gain write and a crossing arrive in the same cycle, the write wins. The new value becomes pending and nothing is applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Audio sample strobe |
| smp_data | input | SAMPLE_W | Signed audio sample |
| fsync_tick | input | 1 | One-cycle pulse per audio frame |
| gain_wr | input | 1 | Gain write strobe |
| gain_wdata | input | GAIN_W | Requested gain |
| tc_wr | input | 1 | Terminal-count write strobe |
| tc_wdata | input | TC_W | Terminal-count value |
| gain_active | output | GAIN_W | Gain presently applied |
| change_pending | output | 1 | A requested gain awaits application |

## Verification
The bench builds the block with its defaults: 16-bit samples, 8-bit gain, a 14-bit terminal count and a floor of 0x0400. Because the bench holds `fsync_tick` high on every cycle during the timed tests, the full range of timeouts stays within the run length. That range covers the floor, the reset default of 8192 ticks and the 16384-tick maximum, as well as a 20000-tick wait with the fallback disabled. The exact-edge checks at N and N+1 ticks are therefore made at the real field limits rather than at shrunken ones.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;

  // Which event, if any, moves the active gain this cycle.
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_ZC    = 2'd2,
    UPD_TMO   = 2'd3
  } upd_src_e;

endpackage

// File: rtl/zc_sign_track.sv
module zc_sign_track #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                zc_hit
);

  localparam int MSB = SAMPLE_W - 1;

  logic prev_sign_q, prev_sign_d;
  logic seen_q, seen_d;
  logic cur_sign, is_zero;

  assign cur_sign = smp_data[MSB];
  assign is_zero  = (smp_data == '0);

  always_comb begin
    prev_sign_d = prev_sign_q;
    seen_d      = seen_q;
    if (smp_valid) begin
      prev_sign_d = cur_sign;
      seen_d      = 1'b1;
    end
  end

  assign zc_hit = smp_valid & (is_zero | (seen_q & (cur_sign != prev_sign_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sign_q <= 1'b0;
      seen_q      <= 1'b0;
    end else if (smp_valid) begin
      prev_sign_q <= prev_sign_d;
      seen_q      <= seen_d;
    end
  end

  // R3: once a sample has been seen, sign history is never forgotten
  p_seen_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);

  // R3: sign history only moves on accepted samples
  p_sign_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(prev_sign_q));

endmodule

// File: rtl/zc_tc_reg.sv
module zc_tc_reg #(
  parameter int              TC_W   = 14,
  parameter logic [TC_W-1:0] TC_RST = 14'h1FFF,
  parameter logic [TC_W-1:0] TC_MIN = 14'h0400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tc_wr,
  input  logic [TC_W-1:0] tc_wdata,
  output logic [TC_W-1:0] tc_eff
);

  logic [TC_W-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     raw_q <= TC_RST;
    else if (tc_wr) raw_q <= tc_wdata;
  end

  // Zero passes through (disable); reserved low values rise to the floor.
  always_comb begin
    if (raw_q == '0)          tc_eff = '0;
    else if (raw_q < TC_MIN)  tc_eff = TC_MIN;
    else                      tc_eff = raw_q;
  end

  // R7: effective count is never in the reserved band
  p_eff_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_eff == '0) || (tc_eff >= TC_MIN));

endmodule

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int TC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            run,
  input  logic            tick,
  input  logic [TC_W-1:0] lim_in,
  output logic            tmo_hit
);

  logic [TC_W-1:0] lim_q, lim_d;
  logic [TC_W-1:0] cnt_q, cnt_d;
  logic            enabled, at_end, cnt_en;

  assign enabled = (lim_q != '0);
  assign at_end  = (cnt_q == lim_q);
  assign tmo_hit = run & tick & enabled & at_end;
  assign cnt_en  = arm | (run & tick & enabled & ~at_end);

  always_comb begin
    lim_d = lim_q;
    cnt_d = cnt_q;
    if (arm) begin
      lim_d = lim_in;
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: the count never runs past the limit it was armed with
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  // R6: a disabled timer stays idle and never fires
  p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |-> (cnt_q == '0) && !tmo_hit);

  // R10: the limit only changes when a new change is armed
  p_lim_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(lim_q));

endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
  parameter int                SAMPLE_W = 16,
  parameter int                GAIN_W   = 8,
  parameter int                TC_W     = 14,
  parameter logic [GAIN_W-1:0] GAIN_RST = '0,
  parameter logic [TC_W-1:0]   TC_RST   = 14'h1FFF,
  parameter logic [TC_W-1:0]   TC_MIN   = 14'h0400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                fsync_tick,
  input  logic                gain_wr,
  input  logic [GAIN_W-1:0]   gain_wdata,
  input  logic                tc_wr,
  input  logic [TC_W-1:0]     tc_wdata,
  output logic [GAIN_W-1:0]   gain_active,
  output logic                change_pending
);

  import zc_gain_pkg::*;

  logic [GAIN_W-1:0] gain_q, gain_d;
  logic [GAIN_W-1:0] pgain_q, pgain_d;
  logic              pend_q, pend_d;
  logic              zc_hit, tmo_hit, arm, same_val;
  logic [TC_W-1:0]   tc_eff;
  upd_src_e          src;

  zc_sign_track #(.SAMPLE_W(SAMPLE_W)) u_sign (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .zc_hit    (zc_hit)
  );

  zc_tc_reg #(.TC_W(TC_W), .TC_RST(TC_RST), .TC_MIN(TC_MIN)) u_tc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc_wr    (tc_wr),
    .tc_wdata (tc_wdata),
    .tc_eff   (tc_eff)
  );

  zc_timeout #(.TC_W(TC_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .run     (pend_q),
    .tick    (fsync_tick),
    .lim_in  (tc_eff),
    .tmo_hit (tmo_hit)
  );

  assign same_val = (gain_wdata == gain_q);
  assign arm      = gain_wr & ~same_val;

  // Event selection: a host write outranks a crossing, which outranks the timer.
  always_comb begin
    if (gain_wr)                 src = UPD_WRITE;
    else if (pend_q && zc_hit)   src = UPD_ZC;
    else if (pend_q && tmo_hit)  src = UPD_TMO;
    else                         src = UPD_NONE;
  end

  always_comb begin
    gain_d  = gain_q;
    pgain_d = pgain_q;
    pend_d  = pend_q;
    unique case (src)
      UPD_WRITE: begin
        if (same_val) begin
          pend_d = 1'b0;
        end else begin
          pgain_d = gain_wdata;
          pend_d  = 1'b1;
        end
      end
      UPD_ZC, UPD_TMO: begin
        gain_d = pgain_q;
        pend_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= GAIN_RST;
      pgain_q <= GAIN_RST;
      pend_q  <= 1'b0;
    end else if (src != UPD_NONE) begin
      gain_q  <= gain_d;
      pgain_q <= pgain_d;
      pend_q  <= pend_d;
    end
  end

  assign gain_active    = gain_q;
  assign change_pending = pend_q;

  // R4: whenever the active gain moves, nothing is left pending
  p_clear_on_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q != $past(gain_q)) |-> !pend_q);

  // R2: the active gain only moves out of a pending state
  p_update_needs_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q != $past(gain_q)) |-> $past(pend_q));

  // R9: an equal write never leaves a change pending
  p_equal_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_wr && gain_wdata == gain_active) |=> !change_pending && $stable(gain_active));

  // R8 / R11: a differing write always becomes the pending value, active held
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_wr && gain_wdata != gain_active) |=> change_pending && $stable(gain_active)
      && (pgain_q == $past(gain_wdata)));

endmodule

// File: tb/zc_gain_ctrl_tb.sv
`timescale 1ns/1ps
module zc_gain_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic        fsync_tick;
  logic        gain_wr;
  logic [7:0]  gain_wdata;
  logic        tc_wr;
  logic [13:0] tc_wdata;
  logic [7:0]  gain_active;
  logic        change_pending;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  zc_gain_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_valid      (smp_valid),
    .smp_data       (smp_data),
    .fsync_tick     (fsync_tick),
    .gain_wr        (gain_wr),
    .gain_wdata     (gain_wdata),
    .tc_wr          (tc_wr),
    .tc_wdata       (tc_wdata),
    .gain_active    (gain_active),
    .change_pending (change_pending)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: {wr, wdata[8], valid, sample[16], exp_gain[8], exp_pend}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 16'h0100, 8'h00, 1'b0},  // R3 first sample, no history
    {1'b1, 8'h20, 1'b0, 16'h0000, 8'h00, 1'b1},  // R2 write pends
    {1'b0, 8'h00, 1'b1, 16'h0200, 8'h00, 1'b1},  // R2 same sign holds
    {1'b0, 8'h00, 1'b0, 16'h8000, 8'h00, 1'b1},  // R3 invalid sample ignored
    {1'b0, 8'h00, 1'b1, 16'h0050, 8'h00, 1'b1},  // R3 history not disturbed
    {1'b0, 8'h00, 1'b1, 16'hFF00, 8'h20, 1'b0},  // R4 sign flip applies
    {1'b1, 8'h35, 1'b0, 16'h0000, 8'h20, 1'b1},  // R2
    {1'b0, 8'h00, 1'b1, 16'hFE00, 8'h20, 1'b1},  // R3 still negative
    {1'b0, 8'h00, 1'b1, 16'h0000, 8'h35, 1'b0},  // R3 exact zero applies
    {1'b1, 8'h35, 1'b0, 16'h0000, 8'h35, 1'b0},  // R9 equal write
    {1'b1, 8'h40, 1'b1, 16'h0010, 8'h35, 1'b1},  // R3 zero then positive: no cross
    {1'b1, 8'h41, 1'b1, 16'h8001, 8'h35, 1'b1},  // R11 write beats crossing
    {1'b0, 8'h00, 1'b1, 16'h7000, 8'h41, 1'b0}   // R8 replaced value applied
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [7:0] eg, input logic ep);
    chk(gain_active == eg, req, gain_active, eg);
    chk(change_pending == ep, req, change_pending, ep);
  endtask

  task automatic wr_gain(input logic [7:0] g);
    gain_wr = 1'b1; gain_wdata = g;
    @(negedge clk);
    gain_wr = 1'b0;
  endtask

  task automatic wr_tc(input logic [13:0] t);
    tc_wr = 1'b1; tc_wdata = t;
    @(negedge clk);
    tc_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    fsync_tick = 1'b1;
    repeat (n) @(negedge clk);
    fsync_tick = 1'b0;
  endtask

  task automatic sample(input logic [15:0] s);
    smp_valid = 1'b1; smp_data = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        summary();
      end
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; fsync_tick = 1'b0;
    gain_wr = 1'b0; gain_wdata = '0; tc_wr = 1'b0; tc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1 reset state", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      gain_wr    = VEC[i][34];
      gain_wdata = VEC[i][33:26];
      smp_valid  = VEC[i][25];
      smp_data   = VEC[i][24:9];
      @(negedge clk);
      gain_wr = 1'b0; smp_valid = 1'b0;
      chk_out($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R1/R5: reset default 0x1FFF -> 8192 ticks
    wr_gain(8'h50);
    ticks(8191);
    chk_out("R1 default count, tick 8191", 8'h41, 1'b1);
    ticks(1);
    chk_out("R1 default count, tick 8192", 8'h50, 1'b0);

    // R5: floor value 0x0400 -> 1025 ticks
    wr_tc(14'h0400);
    wr_gain(8'h51);
    ticks(1024);
    chk_out("R5 0x400 tick 1024", 8'h50, 1'b1);
    ticks(1);
    chk_out("R5 0x400 tick 1025", 8'h51, 1'b0);

    // R7: reserved values behave as 0x0400
    wr_tc(14'h0001);
    wr_gain(8'h52);
    ticks(1024);
    chk_out("R7 0x001 tick 1024", 8'h51, 1'b1);
    ticks(1);
    chk_out("R7 0x001 tick 1025", 8'h52, 1'b0);
    wr_tc(14'h03FF);
    wr_gain(8'h5A);
    ticks(1024);
    chk_out("R7 0x3FF tick 1024", 8'h52, 1'b1);
    ticks(1);
    chk_out("R7 0x3FF tick 1025", 8'h5A, 1'b0);

    // R6: zero disables; only a crossing applies (last accepted sample positive)
    wr_tc(14'h0000);
    wr_gain(8'h53);
    ticks(20000);
    chk_out("R6 disabled after 20000 ticks", 8'h5A, 1'b1);
    sample(16'hF000);
    chk_out("R6 crossing still applies", 8'h53, 1'b0);

    // R5: maximum 0x3FFF -> 16384 ticks
    wr_tc(14'h3FFF);
    wr_gain(8'h54);
    ticks(16383);
    chk_out("R5 0x3FFF tick 16383", 8'h53, 1'b1);
    ticks(1);
    chk_out("R5 0x3FFF tick 16384", 8'h54, 1'b0);

    // R8: rewrite restarts the count
    wr_tc(14'h0400);
    wr_gain(8'h55);
    ticks(1000);
    wr_gain(8'h56);
    ticks(1024);
    chk_out("R8 restart tick 1024 after rewrite", 8'h54, 1'b1);
    ticks(1);
    chk_out("R8 restart tick 1025 after rewrite", 8'h56, 1'b0);

    // R9: equal write cancels a pending change
    wr_gain(8'h60);
    wr_gain(8'h56);
    chk_out("R9 equal write cancels", 8'h56, 1'b0);
    ticks(1100);
    chk_out("R9 nothing applied later", 8'h56, 1'b0);

    // R10: count write mid-change affects the next change only
    wr_gain(8'h57);
    ticks(10);
    wr_tc(14'h0800);
    ticks(1014);
    chk_out("R10 old limit tick 1024", 8'h56, 1'b1);
    ticks(1);
    chk_out("R10 old limit tick 1025", 8'h57, 1'b0);
    wr_gain(8'h58);
    ticks(2048);
    chk_out("R10 new limit tick 2048", 8'h57, 1'b1);
    ticks(1);
    chk_out("R10 new limit tick 2049", 8'h58, 1'b0);

    // R1: mid-run reset restores defaults
    wr_gain(8'h70);
    rst_n = 1'b0;
    #1;
    chk_out("R1 async reset", 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr_gain(8'h71);
    ticks(8191);
    chk_out("R1 count restored, tick 8191", 8'h00, 1'b1);
    ticks(1);
    chk_out("R1 count restored, tick 8192", 8'h71, 1'b0);

    summary();
  end

endmodule